// File: doc/BRIEF.md
# Teletext Request Strobe and Line Gate

This block paces an external teletext bit source line by line. It counts system clocks from the leading edge of each horizontal sync pulse. On lines that the configuration marks as eligible, it raises a request strobe between two programmable clock positions. Separately, it raises an insertion-window flag for a fixed span of clocks. That span is long enough to carry the longest teletext payload. Its start position is fixed, chosen so that the inserted data lands at the required offset after sync once the downstream interpolation and pipeline delays are taken into account.

Eligibility depends on the field. Odd and even fields each have their own inclusive range of line numbers, and one global enable gates everything. All configuration inputs are copied into shadow registers only when the field identifier changes. Software can therefore rewrite them at any time without breaking a line that is in progress.

The block has no data path, so there is no valid/ready handshake and no back-pressure. The request and window outputs are plain level signals, and the external source is expected to follow the request on its own. Bit sampling, filtering and analog insertion happen elsewhere.

Top module: `text_req_gate`

## Requirements
- R1: After reset, and until the first hsync rising edge, req_o and win_o are both 0, whatever the configuration inputs hold.
- R2: A clock edge where hsync is 1 and was 0 at the previous edge is a line start. At that edge the position count becomes 0, and it then rises by one per clock. req_o is 1 in exactly the cycles whose count n satisfies start <= n < stop, provided the line is eligible.
- R3: When the shadowed start position is greater than or equal to the shadowed stop position, req_o stays 0 for the whole line.
- R4: When the line-start field identifier is 1 (odd), a line is eligible only if odd_first <= line_num <= odd_last. line_num is sampled at the line start, and both bounds are inclusive.
- R5: When the line-start field identifier is 0 (even), a line is eligible only if even_first <= line_num <= even_last. The odd range has no influence on this decision.
- R6: When the shadowed enable is 0, req_o and win_o stay 0 on every line.
- R7: On an eligible line, win_o is 1 in exactly the counts WIN_START <= n < WIN_START + ceil(TXT_BITS*SEQ_CLKS/SEQ_BITS). The request start and stop positions have no effect on it.
- R8: The configuration inputs are copied to the shadow registers only at a clock edge where field_odd differs from its value at the previous edge. Changes at any other time have no effect until the next field change.
- R9: A new hsync rising edge ends the current line and restarts the count. Without one, the count stops at 2^HCNT_W-1 and never wraps. At that final count req_o and win_o are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync | input | 1 | Horizontal sync; its rising edge starts a line |
| field_odd | input | 1 | Field identifier, 1 = odd, 0 = even; a change marks a field start |
| line_num | input | LINE_W | Current line number, sampled at line start |
| cfg_en | input | 1 | Global enable for request and window |
| cfg_req_start | input | HCNT_W | Clock position where the request rises |
| cfg_req_stop | input | HCNT_W | Clock position where the request falls (exclusive) |
| cfg_odd_first | input | LINE_W | First eligible line of the odd field |
| cfg_odd_last | input | LINE_W | Last eligible line of the odd field |
| cfg_even_first | input | LINE_W | First eligible line of the even field |
| cfg_even_last | input | LINE_W | Last eligible line of the even field |
| req_o | output | 1 | Request strobe toward the teletext source |
| win_o | output | 1 | Internal insertion-window flag |

## Verification
The bench uses HCNT_W=8, LINE_W=6, WIN_START=20 and TXT_BITS=SEQ_BITS=37 with SEQ_CLKS=144. With these values the window is 144 clocks long, spanning counts 20 to 163. The count saturates at 255, which a line of a few hundred clocks reaches, so both the no-wrap behaviour and the quiet final count can be observed. The small line width lets the bench probe both edges of each field's range, and lines that sit in one field's range but not the other's.

// File: rtl/text_gate_pkg.sv
package text_gate_pkg;
  typedef enum logic {
    PAR_EVEN = 1'b0,
    PAR_ODD  = 1'b1
  } parity_e;

  // integer ceiling division for derived window length
  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction
endpackage

// File: rtl/line_timer.sv
module line_timer #(
  parameter int HCNT_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync,
  output logic              line_start_o,
  output logic [HCNT_W-1:0] hcnt_o,
  output logic              live_o
);
  localparam logic [HCNT_W-1:0] HMAX = {HCNT_W{1'b1}};

  logic hsync_q;

  assign line_start_o = hsync & ~hsync_q;
  assign live_o       = (hcnt_o != HMAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hsync_q <= 1'b0;
      hcnt_o  <= HMAX;   // idle: saturated until the first line start
    end else begin
      hsync_q <= hsync;
      if (line_start_o)
        hcnt_o <= '0;
      else if (hcnt_o != HMAX)
        hcnt_o <= hcnt_o + 1'b1;
    end
  end

  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    line_start_o |=> (hcnt_o == '0)); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_start_o && hcnt_o != HMAX) |=> (hcnt_o == $past(hcnt_o) + 1'b1)); // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_start_o && hcnt_o == HMAX) |=> (hcnt_o == HMAX)); // R9
endmodule

// File: rtl/cfg_shadow.sv
module cfg_shadow #(
  parameter int HCNT_W = 11,
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              field_odd,
  input  logic              cfg_en,
  input  logic [HCNT_W-1:0] cfg_req_start,
  input  logic [HCNT_W-1:0] cfg_req_stop,
  input  logic [LINE_W-1:0] cfg_odd_first,
  input  logic [LINE_W-1:0] cfg_odd_last,
  input  logic [LINE_W-1:0] cfg_even_first,
  input  logic [LINE_W-1:0] cfg_even_last,
  output logic              sh_en,
  output logic [HCNT_W-1:0] sh_start,
  output logic [HCNT_W-1:0] sh_stop,
  output logic [LINE_W-1:0] sh_odd_first,
  output logic [LINE_W-1:0] sh_odd_last,
  output logic [LINE_W-1:0] sh_even_first,
  output logic [LINE_W-1:0] sh_even_last
);
  import text_gate_pkg::*;

  parity_e field_q;
  logic    field_change;

  assign field_change = (parity_e'(field_odd) != field_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      field_q       <= PAR_EVEN;
      sh_en         <= 1'b0;
      sh_start      <= '0;
      sh_stop       <= '0;
      sh_odd_first  <= '0;
      sh_odd_last   <= '0;
      sh_even_first <= '0;
      sh_even_last  <= '0;
    end else begin
      field_q <= parity_e'(field_odd);
      if (field_change) begin
        sh_en         <= cfg_en;
        sh_start      <= cfg_req_start;
        sh_stop       <= cfg_req_stop;
        sh_odd_first  <= cfg_odd_first;
        sh_odd_last   <= cfg_odd_last;
        sh_even_first <= cfg_even_first;
        sh_even_last  <= cfg_even_last;
      end
    end
  end

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !field_change |=> ($stable(sh_en) && $stable(sh_start) && $stable(sh_stop)
                       && $stable(sh_odd_first) && $stable(sh_odd_last)
                       && $stable(sh_even_first) && $stable(sh_even_last))); // R8
endmodule

// File: rtl/line_qual.sv
module line_qual #(
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic              field_odd,
  input  logic [LINE_W-1:0] line_num,
  input  logic              sh_en,
  input  logic [LINE_W-1:0] sh_odd_first,
  input  logic [LINE_W-1:0] sh_odd_last,
  input  logic [LINE_W-1:0] sh_even_first,
  input  logic [LINE_W-1:0] sh_even_last,
  output logic              elig_o
);
  import text_gate_pkg::*;

  logic [LINE_W-1:0] line_q;
  parity_e           par_q;
  logic              in_odd, in_even;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= '0;
      par_q  <= PAR_EVEN;
    end else if (line_start) begin
      line_q <= line_num;
      par_q  <= parity_e'(field_odd);
    end
  end

  always_comb begin
    in_odd  = (line_q >= sh_odd_first)  && (line_q <= sh_odd_last);
    in_even = (line_q >= sh_even_first) && (line_q <= sh_even_last);
    elig_o  = sh_en && ((par_q == PAR_ODD) ? in_odd : in_even);
  end

  AST_ELIG_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    (elig_o && par_q == PAR_ODD) |-> (line_q <= sh_odd_last)); // R4
  AST_ELIG_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (elig_o && par_q == PAR_EVEN) |-> (line_q >= sh_even_first)); // R5
endmodule

// File: rtl/span_cmp.sv
module span_cmp #(
  parameter int SW = 12
) (
  input  logic          gate,
  input  logic [SW-1:0] pos,
  input  logic [SW-1:0] lo,
  input  logic [SW-1:0] hi,
  output logic          hit_o
);
  assign hit_o = gate && (pos >= lo) && (pos < hi);
endmodule

// File: rtl/text_req_gate.sv
module text_req_gate #(
  parameter int HCNT_W    = 11,
  parameter int LINE_W    = 10,
  parameter int WIN_START = 275,
  parameter int TXT_BITS  = 360,
  parameter int SEQ_BITS  = 37,
  parameter int SEQ_CLKS  = 144
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync,
  input  logic              field_odd,
  input  logic [LINE_W-1:0] line_num,
  input  logic              cfg_en,
  input  logic [HCNT_W-1:0] cfg_req_start,
  input  logic [HCNT_W-1:0] cfg_req_stop,
  input  logic [LINE_W-1:0] cfg_odd_first,
  input  logic [LINE_W-1:0] cfg_odd_last,
  input  logic [LINE_W-1:0] cfg_even_first,
  input  logic [LINE_W-1:0] cfg_even_last,
  output logic              req_o,
  output logic              win_o
);
  import text_gate_pkg::*;

  localparam int WIN_LEN = ceil_div(TXT_BITS * SEQ_CLKS, SEQ_BITS);
  localparam int HMAX    = (1 << HCNT_W) - 1;
  localparam int WIN_END = WIN_START + WIN_LEN;
  localparam int WIN_HI  = (WIN_END > HMAX) ? HMAX : WIN_END;
  localparam int SW      = HCNT_W + 1;
  localparam int NSPAN   = 2;   // 0: request, 1: insertion window

  logic              line_start, live, elig;
  logic [HCNT_W-1:0] hcnt;
  logic              sh_en;
  logic [HCNT_W-1:0] sh_start, sh_stop;
  logic [LINE_W-1:0] sh_odd_first, sh_odd_last, sh_even_first, sh_even_last;
  logic [SW-1:0]     span_lo [NSPAN];
  logic [SW-1:0]     span_hi [NSPAN];
  logic [NSPAN-1:0]  span_hit;

  line_timer #(.HCNT_W(HCNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .hsync(hsync),
    .line_start_o(line_start), .hcnt_o(hcnt), .live_o(live)
  );

  cfg_shadow #(.HCNT_W(HCNT_W), .LINE_W(LINE_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .field_odd(field_odd),
    .cfg_en(cfg_en), .cfg_req_start(cfg_req_start), .cfg_req_stop(cfg_req_stop),
    .cfg_odd_first(cfg_odd_first), .cfg_odd_last(cfg_odd_last),
    .cfg_even_first(cfg_even_first), .cfg_even_last(cfg_even_last),
    .sh_en(sh_en), .sh_start(sh_start), .sh_stop(sh_stop),
    .sh_odd_first(sh_odd_first), .sh_odd_last(sh_odd_last),
    .sh_even_first(sh_even_first), .sh_even_last(sh_even_last)
  );

  line_qual #(.LINE_W(LINE_W)) u_qual (
    .clk(clk), .rst_n(rst_n), .line_start(line_start),
    .field_odd(field_odd), .line_num(line_num), .sh_en(sh_en),
    .sh_odd_first(sh_odd_first), .sh_odd_last(sh_odd_last),
    .sh_even_first(sh_even_first), .sh_even_last(sh_even_last),
    .elig_o(elig)
  );

  assign span_lo[0] = {1'b0, sh_start};
  assign span_hi[0] = {1'b0, sh_stop};
  assign span_lo[1] = SW'(WIN_START);
  assign span_hi[1] = SW'(WIN_HI);

  for (genvar g = 0; g < NSPAN; g++) begin : g_span
    span_cmp #(.SW(SW)) u_span (
      .gate(elig & live), .pos({1'b0, hcnt}),
      .lo(span_lo[g]), .hi(span_hi[g]), .hit_o(span_hit[g])
    );
  end

  assign req_o = span_hit[0];
  assign win_o = span_hit[1];

  AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> sh_en); // R6
  AST_WIN_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    win_o |-> sh_en); // R6
  AST_REQ_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> (sh_start < sh_stop)); // R3
  AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    win_o |-> (int'(hcnt) >= WIN_START && int'(hcnt) < WIN_HI)); // R7
  AST_QUIET_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !live |-> (!req_o && !win_o)); // R9
endmodule

// File: tb/text_req_gate_bench.sv
module text_req_gate_bench;
  localparam int HW  = 8;
  localparam int LW  = 6;
  localparam int WS  = 20;
  localparam int TB  = 37;
  localparam int SB  = 37;
  localparam int SC  = 144;
  localparam int WL  = (TB * SC + SB - 1) / SB;
  localparam int MAXC = (1 << HW) - 1;

  logic clk = 1'b0, rst_n = 1'b0, hsync = 1'b0, field_odd = 1'b0;
  logic [LW-1:0] line_num = '0;
  logic          cfg_en = 1'b0;
  logic [HW-1:0] cfg_req_start = '0, cfg_req_stop = '0;
  logic [LW-1:0] cfg_odd_first = '0, cfg_odd_last = '0;
  logic [LW-1:0] cfg_even_first = '0, cfg_even_last = '0;
  logic req_o, win_o;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  bit m_en = 1'b0;
  int m_start = 0, m_stop = 0, m_of = 0, m_ol = 0, m_ef = 0, m_el = 0;

  always #4 clk = ~clk;

  text_req_gate #(.HCNT_W(HW), .LINE_W(LW), .WIN_START(WS),
                  .TXT_BITS(TB), .SEQ_BITS(SB), .SEQ_CLKS(SC)) u_text_req_gate (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .field_odd(field_odd),
    .line_num(line_num), .cfg_en(cfg_en), .cfg_req_start(cfg_req_start),
    .cfg_req_stop(cfg_req_stop), .cfg_odd_first(cfg_odd_first),
    .cfg_odd_last(cfg_odd_last), .cfg_even_first(cfg_even_first),
    .cfg_even_last(cfg_even_last), .req_o(req_o), .win_o(win_o)
  );

  task automatic report(string tag, string what, bit bad, int n, logic act, logic exp);
    checks++;
    if (bad) begin
      failures++;
      $display("FAIL %s %s: first mismatch at count %0d actual=%0b expected=%0b",
               tag, what, n, act, exp);
    end
  endtask

  task automatic set_cfg(bit en, int s, int e, int of, int ol, int ef, int el);
    @(negedge clk);
    cfg_en = en; cfg_req_start = HW'(s); cfg_req_stop = HW'(e);
    cfg_odd_first = LW'(of); cfg_odd_last = LW'(ol);
    cfg_even_first = LW'(ef); cfg_even_last = LW'(el);
  endtask

  // field change: shadow copy happens at the next edge
  task automatic new_field(bit odd);
    @(negedge clk);
    field_odd = odd;
    m_en = cfg_en; m_start = int'(cfg_req_start); m_stop = int'(cfg_req_stop);
    m_of = int'(cfg_odd_first); m_ol = int'(cfg_odd_last);
    m_ef = int'(cfg_even_first); m_el = int'(cfg_even_last);
    @(negedge clk);
  endtask

  task automatic run_line(string tag, int ln, int ncyc);
    bit ok, bad_r, bad_w;
    int nr, nw;
    logic ar, er_f, aw, ew_f;
    bad_r = 0; bad_w = 0; nr = 0; nw = 0;
    ar = 0; er_f = 0; aw = 0; ew_f = 0;
    @(negedge clk);
    hsync = 1'b1; line_num = LW'(ln);
    @(negedge clk);
    hsync = 1'b0;
    ok = m_en && (field_odd ? (ln >= m_of && ln <= m_ol) : (ln >= m_ef && ln <= m_el));
    for (int n = 0; n < ncyc; n++) begin
      int c;
      bit live;
      logic er, ew;
      c = (n > MAXC) ? MAXC : n;
      live = (c < MAXC);
      er = ok && live && c >= m_start && c < m_stop;
      ew = ok && live && c >= WS && c < WS + WL;
      if (req_o !== er && !bad_r) begin bad_r = 1; nr = n; ar = req_o; er_f = er; end
      if (win_o !== ew && !bad_w) begin bad_w = 1; nw = n; aw = win_o; ew_f = ew; end
      @(negedge clk);
    end
    report(tag, "req_o", bad_r, nr, ar, er_f);
    report(tag, "win_o", bad_w, nw, aw, ew_f);
  endtask

  task automatic t_reset();
    bit bad;
    bad = 0;
    cfg_en = 1'b1; cfg_req_start = '0; cfg_req_stop = 8'd200;
    cfg_odd_last = '1; cfg_even_last = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) begin
      if (req_o !== 1'b0 || win_o !== 1'b0) bad = 1;
      @(negedge clk);
    end
    report("R1", "idle after reset", bad, 0, req_o | win_o, 1'b0);
  endtask

  task automatic t_odd_lines();
    set_cfg(1, 30, 60, 5, 8, 10, 12);
    new_field(1);
    run_line("R2 R7 odd line 5", 5, 260);
    run_line("R4 upper bound line 8", 8, 200);
    run_line("R4 above range line 9", 9, 200);
    run_line("R4 below range line 4", 4, 200);
  endtask

  task automatic t_even_lines();
    new_field(0);
    run_line("R5 lower bound line 10", 10, 200);
    run_line("R5 upper bound line 12", 12, 200);
    run_line("R5 below range line 9", 9, 200);
    run_line("R5 above range line 13", 13, 200);
    run_line("R5 odd-only line 6", 6, 200);
  endtask

  task automatic t_disable();
    set_cfg(0, 30, 60, 5, 8, 10, 12);
    new_field(1);
    run_line("R6 enable off", 6, 200);
  endtask

  task automatic t_bad_order();
    set_cfg(1, 60, 60, 5, 8, 10, 12);
    new_field(0);
    run_line("R3 start equals stop", 11, 200);
    set_cfg(1, 70, 40, 5, 8, 10, 12);
    new_field(1);
    run_line("R3 start above stop", 6, 200);
  endtask

  task automatic t_shadow();
    set_cfg(1, 30, 60, 5, 8, 10, 12);
    new_field(0);
    set_cfg(1, 100, 120, 5, 8, 10, 12);
    run_line("R8 mid-field change ignored", 11, 200);
    new_field(1);
    run_line("R8 new field applies", 6, 200);
  endtask

  task automatic t_line_end();
    set_cfg(1, 10, 200, 5, 8, 10, 12);
    new_field(0);
    run_line("R9 line cut short", 11, 50);
    run_line("R9 restart on new sync", 11, 60);
    set_cfg(1, 0, 5, 5, 8, 10, 12);
    new_field(1);
    run_line("R9 no wrap", 6, 300);
    set_cfg(1, 200, 255, 5, 8, 10, 12);
    new_field(0);
    run_line("R9 quiet at final count", 11, 300);
  endtask

  initial begin
    t_reset();
    t_odd_lines();
    t_even_lines();
    t_disable();
    t_bad_order();
    t_shadow();
    t_line_end();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule